// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a single load or store, along with the value that may be written back into the base register. It takes a base value, which may be the program counter, and adds or subtracts an offset. The offset is a short immediate, a plain register, or a register passed through a barrel shift. The caller picks pre-indexing, where the access uses the adjusted address, or post-indexing, where the access uses the untouched base. It also says whether the adjusted address goes back into the base register. Post-indexing always writes back. When the base is the program counter, the generator adds a fixed look-ahead of 8 to the instruction address.

The arithmetic is combinational. The results are captured in an output stage one cycle after a request strobe. The block checks alignment for halfword and word transfers. A misaligned access raises a fault flag and cancels the base writeback for that access. The memory port, data rotation, sign extension and multi-register sequencing are handled elsewhere.

Top module: `lsag_top`

## Requirements
- R1: All results appear one clock after `req_valid` is high at a rising edge. `out_valid` is high exactly in the cycle after each strobe. In a cycle that follows no strobe, `out_valid`, `wb_en` and `align_fault` are low. Reset clears every output to zero.
- R2: With `off_sel` = 0 the offset is an immediate, zero-extended. When `imm_narrow` = 0 all 12 bits of `imm_val` are used. When `imm_narrow` = 1 only `imm_val[7:0]` is used and bits 11:8 have no effect.
- R3: With `off_sel` = 1 the offset is `reg_val` without any shift.
- R4: With `off_sel` = 2 or 3 the offset is `reg_val` shifted according to `shift_sel`:
  - 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right, each by `shift_amt`. An amount of 0 leaves the value unshifted.
  - 4 rotates right by one bit through `carry_in`, which enters at the top bit, and ignores `shift_amt`.
  - Codes 5 to 7 pass `reg_val` unshifted.
- R5: `add_dir` = 1 adds the offset to the base and `add_dir` = 0 subtracts it. Both wrap modulo 2^AW.
- R6: With `pre_index` = 1 the effective address is base ± offset, and `wb_en` equals `wb_req` (when there is no fault).
- R7: With `pre_index` = 0 the effective address is the unmodified base, and `wb_en` is 1 (when there is no fault) whatever `wb_req` is.
- R8: `wb_value` is always base ± offset, in both indexing modes.
- R9: When `base_is_pc` = 1 the base is `instr_addr` + 8 and `base_val` has no effect.
- R10: `size_sel` selects the access size: 0 is byte, 1 is halfword, and 2 or 3 is word.
  - A halfword with `eff_addr[0]` = 1 sets `align_fault`.
  - A word with `eff_addr[1:0]` ≠ 0 sets `align_fault`.
  - A byte never sets `align_fault`.
  - A fault forces `wb_en` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| base_val | input | AW | Base register value |
| base_is_pc | input | 1 | Base is the program counter |
| instr_addr | input | AW | Address of the current instruction |
| off_sel | input | 2 | Offset source: 0 immediate, 1 register, 2/3 shifted register |
| imm_narrow | input | 1 | Use the 8-bit immediate form |
| imm_val | input | 12 | Immediate offset |
| reg_val | input | AW | Offset register value |
| shift_sel | input | 3 | Shift kind for the shifted-register offset |
| shift_amt | input | SHW | Shift amount |
| carry_in | input | 1 | Carry flag used by the one-bit rotate-through-carry |
| add_dir | input | 1 | 1 add offset, 0 subtract |
| pre_index | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_req | input | 1 | Writeback requested (pre-indexed only) |
| size_sel | input | 2 | Access size |
| out_valid | output | 1 | Registered results valid |
| eff_addr | output | AW | Effective byte address |
| wb_value | output | AW | Value for the base register |
| wb_en | output | 1 | Base writeback enable |
| align_fault | output | 1 | Misaligned halfword or word access |

## Verification
Every fault in this block surfaces on the outputs in the single cycle after the strobe, because there is no state beyond the output stage.
- A wrong shift kind or a wrong immediate width corrupts `wb_value` for every indexing mode. It also corrupts `eff_addr` for pre-indexed requests.
- Swapped pre and post handling shows up both as a base address where the adjusted one was expected and as a wrong `wb_en`.
- A stale output register shows up as `out_valid` or `wb_en` still high in the idle cycle after a request.

The sweep covers every offset source, every shift kind at the extreme amounts, both directions, both indexing modes, all sizes, and both base sources. Each result is checked in the cycle it is due.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

   typedef enum logic [1:0] {
      OFS_IMM  = 2'd0,
      OFS_REG  = 2'd1,
      OFS_SCL  = 2'd2,
      OFS_SCL2 = 2'd3
   } ofs_sel_e;

   typedef enum logic [2:0] {
      SH_LSL = 3'd0,
      SH_LSR = 3'd1,
      SH_ASR = 3'd2,
      SH_ROR = 3'd3,
      SH_RRX = 3'd4
   } shift_e;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_WORD2 = 2'd3
   } size_e;

endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter #(
   parameter int AW  = 32,
   parameter int SHW = $clog2(AW)
) (
   input  logic [AW-1:0]  val,
   input  logic [2:0]     kind,
   input  logic [SHW-1:0] amt,
   input  logic           cin,
   output logic [AW-1:0]  res
);
   import lsag_pkg::*;

   logic [SHW:0]   inv_amt;
   logic [AW-1:0]  rot;

   // Left-shift amount that completes a right rotation.
   assign inv_amt = (SHW+1)'(AW) - {1'b0, amt};
   assign rot     = (amt == '0) ? val : ((val >> amt) | (val << inv_amt));

   always_comb begin
      case (kind)
         SH_LSL:  res = val << amt;
         SH_LSR:  res = val >> amt;
         SH_ASR:  res = AW'($signed(val) >>> amt);
         SH_ROR:  res = rot;
         SH_RRX:  res = {cin, val[AW-1:1]};
         default: res = val;
      endcase
   end

endmodule

// File: rtl/lsag_offset.sv
module lsag_offset #(
   parameter int AW       = 32,
   parameter int SHW      = $clog2(AW),
   parameter int IMM_W    = 12,
   parameter int IMM_NW   = 8
) (
   input  logic [1:0]       off_sel,
   input  logic             imm_narrow,
   input  logic [IMM_W-1:0] imm_val,
   input  logic [AW-1:0]    reg_val,
   input  logic [2:0]       shift_sel,
   input  logic [SHW-1:0]   shift_amt,
   input  logic             carry_in,
   output logic [AW-1:0]    offset
);
   import lsag_pkg::*;

   logic [AW-1:0] imm_ext;
   logic [AW-1:0] shifted;

   assign imm_ext = imm_narrow ? AW'(imm_val[IMM_NW-1:0]) : AW'(imm_val);

   lsag_shifter #(.AW(AW), .SHW(SHW)) u_shift (
      .val  (reg_val),
      .kind (shift_sel),
      .amt  (shift_amt),
      .cin  (carry_in),
      .res  (shifted)
   );

   always_comb begin
      case (off_sel)
         OFS_IMM: offset = imm_ext;
         OFS_REG: offset = reg_val;
         default: offset = shifted;
      endcase
   end

endmodule

// File: rtl/lsag_adder.sv
module lsag_adder #(
   parameter int AW        = 32,
   parameter int PC_AHEAD  = 8,
   parameter bit PC_BASE_EN = 1'b1
) (
   input  logic [AW-1:0] base_val,
   input  logic          base_is_pc,
   input  logic [AW-1:0] instr_addr,
   input  logic [AW-1:0] offset,
   input  logic          add_dir,
   input  logic          pre_index,
   output logic [AW-1:0] addr,
   output logic [AW-1:0] adj
);
   logic [AW-1:0] base_eff;

   generate
      if (PC_BASE_EN) begin : g_pc
         assign base_eff = base_is_pc ? (instr_addr + AW'(PC_AHEAD)) : base_val;
      end else begin : g_nopc
         logic unused_pc;
         assign unused_pc = base_is_pc ^ (^instr_addr);
         assign base_eff  = base_val;
      end
   endgenerate

   assign adj  = add_dir ? (base_eff + offset) : (base_eff - offset);
   assign addr = pre_index ? adj : base_eff;

endmodule

// File: rtl/lsag_align.sv
module lsag_align #(
   parameter int AW       = 32,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    size_sel,
   output logic          fault
);
   import lsag_pkg::*;

   generate
      if (CHECK_EN) begin : g_chk
         always_comb begin
            case (size_sel)
               SZ_BYTE: fault = 1'b0;
               SZ_HALF: fault = addr[0];
               default: fault = (addr[1:0] != 2'b00);
            endcase
         end
         if (AW > 2) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^addr[AW-1:2];
         end
      end else begin : g_off
         logic unused_a;
         assign unused_a = (^addr) ^ (^size_sel);
         assign fault    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/lsag_top.sv
module lsag_top #(
   parameter int AW           = 32,
   parameter int IMM_W        = 12,
   parameter int IMM_NW       = 8,
   parameter int PC_AHEAD     = 8,
   parameter bit PC_BASE_EN   = 1'b1,
   parameter bit ALIGN_CHK_EN = 1'b1,
   localparam int SHW         = $clog2(AW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [AW-1:0]    base_val,
   input  logic             base_is_pc,
   input  logic [AW-1:0]    instr_addr,
   input  logic [1:0]       off_sel,
   input  logic             imm_narrow,
   input  logic [IMM_W-1:0] imm_val,
   input  logic [AW-1:0]    reg_val,
   input  logic [2:0]       shift_sel,
   input  logic [SHW-1:0]   shift_amt,
   input  logic             carry_in,
   input  logic             add_dir,
   input  logic             pre_index,
   input  logic             wb_req,
   input  logic [1:0]       size_sel,
   output logic             out_valid,
   output logic [AW-1:0]    eff_addr,
   output logic [AW-1:0]    wb_value,
   output logic             wb_en,
   output logic             align_fault
);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("lsag_top: AW must be at least 8");
      end
      if (IMM_NW > IMM_W) begin : g_bad_imm
         $error("lsag_top: narrow immediate wider than full immediate");
      end
      if (IMM_W > AW) begin : g_bad_immw
         $error("lsag_top: immediate wider than address");
      end
   endgenerate

   logic [AW-1:0] offset_c;
   logic [AW-1:0] addr_c;
   logic [AW-1:0] adj_c;
   logic          fault_c;
   logic          wb_c;

   lsag_offset #(.AW(AW), .SHW(SHW), .IMM_W(IMM_W), .IMM_NW(IMM_NW)) u_ofs (
      .off_sel    (off_sel),
      .imm_narrow (imm_narrow),
      .imm_val    (imm_val),
      .reg_val    (reg_val),
      .shift_sel  (shift_sel),
      .shift_amt  (shift_amt),
      .carry_in   (carry_in),
      .offset     (offset_c)
   );

   lsag_adder #(.AW(AW), .PC_AHEAD(PC_AHEAD), .PC_BASE_EN(PC_BASE_EN)) u_add (
      .base_val   (base_val),
      .base_is_pc (base_is_pc),
      .instr_addr (instr_addr),
      .offset     (offset_c),
      .add_dir    (add_dir),
      .pre_index  (pre_index),
      .addr       (addr_c),
      .adj        (adj_c)
   );

   lsag_align #(.AW(AW), .CHECK_EN(ALIGN_CHK_EN)) u_aln (
      .addr     (addr_c),
      .size_sel (size_sel),
      .fault    (fault_c)
   );

   // Post-indexing always updates the base; pre-indexing only on request.
   assign wb_c = (~pre_index | wb_req) & ~fault_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         eff_addr    <= '0;
         wb_value    <= '0;
         wb_en       <= 1'b0;
         align_fault <= 1'b0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            eff_addr    <= addr_c;
            wb_value    <= adj_c;
            wb_en       <= wb_c;
            align_fault <= fault_c;
         end else begin
            wb_en       <= 1'b0;
            align_fault <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
   parameter int AW           = 32,
   parameter bit ALIGN_CHK_EN = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [AW-1:0] base_val,
   input logic          base_is_pc,
   input logic          pre_index,
   input logic          wb_req,
   input logic [1:0]    size_sel,
   input logic          out_valid,
   input logic [AW-1:0] eff_addr,
   input logic          wb_en,
   input logic          align_fault
);

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(req_valid));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!wb_en && !align_fault));

   a_r6_plain_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(pre_index) && !$past(wb_req)) |-> !wb_en);

   a_r7_post_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(pre_index) && !align_fault) |-> wb_en);

   a_r7_post_base: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(pre_index) && !$past(base_is_pc)) |-> (eff_addr == $past(base_val)));

   a_r10_fault_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> !wb_en);

   a_r10_byte_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ($past(size_sel) == 2'd0)) |-> !align_fault);

   generate
      if (ALIGN_CHK_EN) begin : g_al
         a_r10_half_fault: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ($past(size_sel) == 2'd1) && eff_addr[0]) |-> align_fault);
         a_r10_word_fault: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(size_sel[1]) && (eff_addr[1:0] != 2'b00)) |-> align_fault);
      end
   endgenerate

endmodule

bind lsag_top lsag_chk #(.AW(AW), .ALIGN_CHK_EN(ALIGN_CHK_EN)) u_chk (.*);

// File: tb/tb_lsag_top.sv
module tb_lsag_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [31:0] base_val;
   logic        base_is_pc;
   logic [31:0] instr_addr;
   logic [1:0]  off_sel;
   logic        imm_narrow;
   logic [11:0] imm_val;
   logic [31:0] reg_val;
   logic [2:0]  shift_sel;
   logic [4:0]  shift_amt;
   logic        carry_in;
   logic        add_dir;
   logic        pre_index;
   logic        wb_req;
   logic [1:0]  size_sel;
   logic        out_valid;
   logic [31:0] eff_addr;
   logic [31:0] wb_value;
   logic        wb_en;
   logic        align_fault;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsag_top dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_shift(input logic [31:0] r, input int sk,
                                              input int a, input logic c);
      logic [63:0] w;
      case (sk)
         0: begin w = {32'd0, r} * (64'd1 << a); return w[31:0]; end
         1: begin w = {32'd0, r} / (64'd1 << a); return w[31:0]; end
         2: begin w = {{32{r[31]}}, r} >> a;     return w[31:0]; end
         3: begin w = {r, r} >> a;               return w[31:0]; end
         default: return (r / 2) + (c ? 32'h8000_0000 : 32'd0);
      endcase
   endfunction

   task automatic run_one(input int oi, input int dir, input int pre, input int wbq,
                          input int sz, input int pc, input int bi);
      logic [31:0] bases [3];
      logic [31:0] b, off, adj, ea;
      logic        flt, wbe;
      int          sk, am;
      int          amts [4];
      string       etag;
      bases[0] = 32'h0000_1000; bases[1] = 32'hFFFF_FFF2; bases[2] = 32'h8000_0003;
      amts[0] = 0; amts[1] = 1; amts[2] = 3; amts[3] = 31;

      @(negedge clk);
      chk("R1 idle valid", {31'd0, out_valid}, 32'd0);
      chk("R1 idle wb_en", {31'd0, wb_en}, 32'd0);

      req_valid  = 1'b1;
      base_val   = bases[bi];
      base_is_pc = pc[0];
      instr_addr = 32'h0000_2004;
      imm_val    = 12'hA5C;
      reg_val    = 32'h8000_00A5;
      carry_in   = bi[0];
      add_dir    = dir[0];
      pre_index  = pre[0];
      wb_req     = wbq[0];
      size_sel   = sz[1:0];
      sk = 0; am = 0;
      if (oi == 0) begin off_sel = 2'd0; imm_narrow = 1'b0; off = 32'h0000_0A5C; etag = "R2 wide imm"; end
      else if (oi == 1) begin off_sel = 2'd0; imm_narrow = 1'b1; off = 32'h0000_005C; etag = "R2 narrow imm"; end
      else if (oi == 2) begin off_sel = 2'd1; imm_narrow = 1'b0; off = reg_val; etag = "R3 reg"; end
      else begin
         sk = (oi - 3) / 4; am = amts[(oi - 3) % 4];
         off_sel = (oi % 2 == 0) ? 2'd2 : 2'd3; imm_narrow = 1'b0;
         off = ref_shift(reg_val, sk, am, carry_in); etag = "R4 shifted reg";
      end
      shift_sel = sk[2:0];
      shift_amt = am[4:0];
      b   = pc ? 32'h0000_2004 + 32'd8 : bases[bi];
      adj = dir ? b + off : b + (~off + 32'd1);
      ea  = pre ? adj : b;
      flt = (sz == 1) ? ea[0] : ((sz >= 2) ? (ea[1:0] != 2'b00) : 1'b0);
      wbe = (pre ? wbq[0] : 1'b1) && !flt;
      if (pc) etag = "R9 pc base";
      else if (!pre) etag = "R7 post base";
      else if (!dir) etag = "R5 subtract";

      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 valid", {31'd0, out_valid}, 32'd1);
      chk(etag, eff_addr, ea);
      chk(dir ? "R8 wb_value" : "R5 R8 wb_value", wb_value, adj);
      chk("R10 align_fault", {31'd0, align_fault}, {31'd0, flt});
      chk(pre ? "R6 wb_en" : "R7 wb_en", {31'd0, wb_en}, {31'd0, wbe});
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; base_val = '0; base_is_pc = 1'b0;
      instr_addr = '0; off_sel = '0; imm_narrow = 1'b0; imm_val = '0;
      reg_val = '0; shift_sel = '0; shift_amt = '0; carry_in = 1'b0;
      add_dir = 1'b0; pre_index = 1'b0; wb_req = 1'b0; size_sel = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
      chk("R1 reset eff_addr", eff_addr, 32'd0);
      chk("R1 reset wb_value", wb_value, 32'd0);
      chk("R1 reset wb_en", {31'd0, wb_en}, 32'd0);
      rst_n = 1'b1;
      for (int oi = 0; oi < 23; oi++)
         for (int dir = 0; dir < 2; dir++)
            for (int pre = 0; pre < 2; pre++)
               for (int wbq = 0; wbq < 2; wbq++)
                  for (int sz = 0; sz < 3; sz++)
                     for (int pc = 0; pc < 2; pc++)
                        for (int bi = 0; bi < 3; bi++)
                           run_one(oi, dir, pre, wbq, sz, pc, bi);
      // R2: upper immediate bits have no effect in the narrow form
      @(negedge clk);
      req_valid = 1'b1; base_is_pc = 1'b0; base_val = 32'h0000_0100; off_sel = 2'd0;
      imm_narrow = 1'b1; imm_val = 12'hF04; add_dir = 1'b1; pre_index = 1'b1;
      wb_req = 1'b1; size_sel = 2'd2;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 narrow ignores upper bits", wb_value, 32'h0000_0104);
      // R9: base_val has no effect with a PC base
      @(negedge clk);
      req_valid = 1'b1; base_is_pc = 1'b1; base_val = 32'hDEAD_BEEF; instr_addr = 32'h0000_0040;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 pc ignores base_val", wb_value, 32'h0000_004C);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule